// File: doc/BRIEF.md
# Procedure Call Execution Unit

This unit carries out the procedure-call instructions of a small 32-bit processor datapath. The decode stage presents a decoded opcode, the ModRM reg field, the operand size, the immediate displacement, a register operand, the parts of an effective address, the address of the next instruction and the current stack pointer. It raises `start` for one cycle. The unit then works out the branch target and the return address. It pushes the return address through a single memory-write port and reports the new instruction pointer and stack pointer with a one-cycle `done` pulse.

Near calls come in three forms: relative, register-indirect and memory-indirect. A memory-indirect call fetches its target through a read port before the push is issued. When the stack pointer serves as the base of the effective address, its value from before the push is used. Far forms are recognised by opcode and are not executed. They complete at once with a far flag, and they also raise an intercept flag when the decode stage reports a privilege change or a task switch. Any other opcode is left alone.

Top module: `call_exec_unit`

## Requirements
- R1: Opcode 0xE8 is a relative near call. Its target is `next_ip` plus the signed displacement: all 32 bits of `disp_imm` when `wide_op`=1, or `disp_imm[15:0]` sign-extended when `wide_op`=0.
- R2: Opcode 0xFF with `modrm_reg`=2 and `mem_form`=0 is a register-indirect near call whose target is `reg_operand`.
- R3: Opcode 0xFF with `modrm_reg`=2 and `mem_form`=1 issues one read at `base + ea_disp`. The base is `sp_in` (the value before the push) when `base_is_sp`=1 and `base_reg` otherwise. The target is `rd_data`.
- R4: A near call issues one write at `sp_in - 4` (`wide_op`=1) or `sp_in - 2` (`wide_op`=0). The write data is `next_ip`, or `next_ip[15:0]` zero-extended in 16-bit size. `wr_wide` equals `wide_op`, and at `done` the value of `sp_out` equals the write address.
- R5: With `wide_op`=0 the new `ip_out` is the target truncated to its low 16 bits, with bits 31:16 cleared.
- R6: The read completes before the write. `wr_req` and `rd_req` are never high together, and each is a one-cycle pulse in the case of `wr_req`. `done` is a one-cycle pulse in the cycle after the write.
- R7: Opcode 0x9A and opcode 0xFF with `modrm_reg`=3 are far calls. They produce `done` with `far_flag`=1 in the cycle after `start`, make no read and no write, and leave `ip_out` and `sp_out` unchanged.
- R8: A far call with `priv_change`=1 also raises `intercept`, and `intercept` is never high without `far_flag`.
- R9: A `start` with any other opcode, or with 0xFF and a reg field other than 2 or 3, is ignored: no `done`, no memory traffic, and no change to `ip_out` or `sp_out`.
- R10: Synchronous reset aborts any call in progress and clears `done`, `rd_req`, `wr_req`, `ip_out` and `sp_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to execute the presented instruction |
| opcode | input | 8 | Decoded primary opcode |
| modrm_reg | input | 3 | ModRM reg field |
| wide_op | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| disp_imm | input | 32 | Immediate displacement of the relative form |
| reg_operand | input | 32 | Register operand of the register-indirect form |
| mem_form | input | 1 | 1 = indirect target read from memory |
| base_is_sp | input | 1 | Effective-address base is the stack pointer |
| base_reg | input | 32 | Effective-address base register value |
| ea_disp | input | 32 | Effective-address displacement |
| next_ip | input | 32 | Address of the instruction following the call |
| sp_in | input | 32 | Stack pointer before the call |
| priv_change | input | 1 | Far target needs a privilege change or task switch |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Memory write request (one cycle) |
| wr_addr | output | 32 | Memory write address |
| wr_data | output | 32 | Memory write data |
| wr_wide | output | 1 | 1 = 4-byte write, 0 = 2-byte write |
| done | output | 1 | Completion pulse |
| far_flag | output | 1 | Far call recognised, valid with done |
| intercept | output | 1 | Far call needs external handling, valid with done |
| ip_out | output | 32 | Instruction pointer after the last near call |
| sp_out | output | 32 | Stack pointer after the last near call |

## Verification
The assertions check the ordering rules on every cycle. These are the mutual exclusion of read and write, the single-cycle write and done pulses, the write that precedes every near completion, and the absence of traffic and of any pointer change on far completions. They also check that intercept implies far and that a 16-bit near completion leaves the upper instruction-pointer half clear. Only the bench scenarios can show that the arithmetic is right: the sign-extended relative targets, including a 16-bit wrap, the pre-push stack pointer as an address base, the truncated 16-bit targets, the push address and data, and the fact that ignored opcodes and a reset in mid-call leave no trace.

// File: rtl/call_exec_pkg.sv
package call_exec_pkg;
  localparam logic [7:0] OPC_NEAR_REL = 8'hE8;
  localparam logic [7:0] OPC_GRP_IND  = 8'hFF;
  localparam logic [7:0] OPC_FAR_DIR  = 8'h9A;
  localparam logic [2:0] SUB_NEAR     = 3'd2;
  localparam logic [2:0] SUB_FAR      = 3'd3;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_NEAR_REL,
    CK_NEAR_REG,
    CK_NEAR_MEM,
    CK_FAR
  } call_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_FIN
  } call_state_e;
endpackage

// File: rtl/call_classify.sv
module call_classify
  import call_exec_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [2:0] modrm_reg,
  input  logic       mem_form,
  output call_kind_e kind
);
  always_comb begin
    kind = CK_NONE;
    if (opcode == OPC_NEAR_REL) begin
      kind = CK_NEAR_REL;                               // R1
    end else if (opcode == OPC_FAR_DIR) begin
      kind = CK_FAR;                                    // R7
    end else if (opcode == OPC_GRP_IND) begin
      if (modrm_reg == SUB_NEAR)
        kind = mem_form ? CK_NEAR_MEM : CK_NEAR_REG;    // R2, R3
      else if (modrm_reg == SUB_FAR)
        kind = CK_FAR;
    end
  end
endmodule

// File: rtl/call_addr_gen.sv
module call_addr_gen #(
  parameter int XLEN = 32
) (
  input  logic            wide_op,
  input  logic [XLEN-1:0] disp_imm,
  input  logic [XLEN-1:0] next_ip,
  input  logic [XLEN-1:0] sp_in,
  input  logic            base_is_sp,
  input  logic [XLEN-1:0] base_reg,
  input  logic [XLEN-1:0] ea_disp,
  output logic [XLEN-1:0] rel_target,
  output logic [XLEN-1:0] eff_addr,
  output logic [XLEN-1:0] push_addr,
  output logic [XLEN-1:0] ret_val
);
  localparam int HALF       = XLEN / 2;
  localparam int WIDE_BYTES = XLEN / 8;
  localparam int HALF_BYTES = HALF / 8;

  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] base_val;

  always_comb begin
    disp_ext   = wide_op ? disp_imm : {{HALF{disp_imm[HALF-1]}}, disp_imm[HALF-1:0]};
    rel_target = next_ip + disp_ext;
    // pre-push stack pointer serves as the base (R3)
    base_val   = base_is_sp ? sp_in : base_reg;
    eff_addr   = base_val + ea_disp;
    push_addr  = sp_in - (wide_op ? XLEN'(WIDE_BYTES) : XLEN'(HALF_BYTES));
    ret_val    = wide_op ? next_ip : {{HALF{1'b0}}, next_ip[HALF-1:0]};
  end
endmodule

// File: rtl/call_exec_unit.sv
module call_exec_unit
  import call_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [7:0]      opcode,
  input  logic [2:0]      modrm_reg,
  input  logic            wide_op,
  input  logic [XLEN-1:0] disp_imm,
  input  logic [XLEN-1:0] reg_operand,
  input  logic            mem_form,
  input  logic            base_is_sp,
  input  logic [XLEN-1:0] base_reg,
  input  logic [XLEN-1:0] ea_disp,
  input  logic [XLEN-1:0] next_ip,
  input  logic [XLEN-1:0] sp_in,
  input  logic            priv_change,
  output logic            rd_req,
  output logic [XLEN-1:0] rd_addr,
  input  logic            rd_valid,
  input  logic [XLEN-1:0] rd_data,
  output logic            wr_req,
  output logic [XLEN-1:0] wr_addr,
  output logic [XLEN-1:0] wr_data,
  output logic            wr_wide,
  output logic            done,
  output logic            far_flag,
  output logic            intercept,
  output logic [XLEN-1:0] ip_out,
  output logic [XLEN-1:0] sp_out
);
  localparam int HALF = XLEN / 2;

  call_kind_e      kind;
  call_state_e     state;
  logic [XLEN-1:0] rel_target, eff_addr, push_addr, ret_val;
  logic [XLEN-1:0] pend_ip, hold_push, hold_ret;
  logic            hold_wide;

  call_classify u_classify (
    .opcode    (opcode),
    .modrm_reg (modrm_reg),
    .mem_form  (mem_form),
    .kind      (kind)
  );

  call_addr_gen #(.XLEN(XLEN)) u_addr_gen (
    .wide_op    (wide_op),
    .disp_imm   (disp_imm),
    .next_ip    (next_ip),
    .sp_in      (sp_in),
    .base_is_sp (base_is_sp),
    .base_reg   (base_reg),
    .ea_disp    (ea_disp),
    .rel_target (rel_target),
    .eff_addr   (eff_addr),
    .push_addr  (push_addr),
    .ret_val    (ret_val)
  );

  function automatic logic [XLEN-1:0] size_ip(input logic [XLEN-1:0] v, input logic wide);
    return wide ? v : {{HALF{1'b0}}, v[HALF-1:0]};   // R5
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_wide   <= 1'b0;
      done      <= 1'b0;
      far_flag  <= 1'b0;
      intercept <= 1'b0;
      ip_out    <= '0;
      sp_out    <= '0;
      pend_ip   <= '0;
      hold_push <= '0;
      hold_ret  <= '0;
      hold_wide <= 1'b0;
    end else begin
      done      <= 1'b0;
      far_flag  <= 1'b0;
      intercept <= 1'b0;
      wr_req    <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          unique case (kind)
            CK_NEAR_REL, CK_NEAR_REG: begin
              wr_req  <= 1'b1;
              wr_addr <= push_addr;
              wr_data <= ret_val;
              wr_wide <= wide_op;
              pend_ip <= size_ip((kind == CK_NEAR_REL) ? rel_target : reg_operand, wide_op);
              state   <= ST_FIN;
            end
            CK_NEAR_MEM: begin
              rd_req    <= 1'b1;
              rd_addr   <= eff_addr;
              hold_push <= push_addr;
              hold_ret  <= ret_val;
              hold_wide <= wide_op;
              state     <= ST_READ;
            end
            CK_FAR: begin
              done      <= 1'b1;
              far_flag  <= 1'b1;
              intercept <= priv_change;   // R8
            end
            default: ;                    // R9: ignored
          endcase
        end
        ST_READ: if (rd_valid) begin
          rd_req  <= 1'b0;
          wr_req  <= 1'b1;
          wr_addr <= hold_push;
          wr_data <= hold_ret;
          wr_wide <= hold_wide;
          pend_ip <= size_ip(rd_data, hold_wide);
          state   <= ST_FIN;
        end
        ST_FIN: begin
          done   <= 1'b1;
          ip_out <= pend_ip;
          sp_out <= wr_addr;              // R4
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/call_exec_checker.sv
module call_exec_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_req,
  input logic            wr_req,
  input logic            wr_wide,
  input logic            done,
  input logic            far_flag,
  input logic            intercept,
  input logic [XLEN-1:0] ip_out,
  input logic [XLEN-1:0] sp_out
);
  localparam int HALF = XLEN / 2;

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(rd_req && wr_req)); // R6
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (rst) wr_req |=> !wr_req); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst) (done && !far_flag) |-> $past(wr_req)); // R6
  AST_FAR_NO_TRAFFIC: assert property (@(posedge clk) disable iff (rst) far_flag |-> (done && !rd_req && !wr_req)); // R7
  AST_FAR_KEEPS_PTRS: assert property (@(posedge clk) disable iff (rst) far_flag |-> ($stable(ip_out) && $stable(sp_out))); // R7
  AST_INTERCEPT_IS_FAR: assert property (@(posedge clk) disable iff (rst) intercept |-> far_flag); // R8
  AST_NARROW_IP_CLEAR: assert property (@(posedge clk) disable iff (rst) (done && !far_flag && !wr_wide) |-> (ip_out[XLEN-1:HALF] == '0)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!done && !rd_req && !wr_req && ip_out == '0 && sp_out == '0)); // R10
endmodule

bind call_exec_unit call_exec_checker #(.XLEN(XLEN)) u_call_exec_checker (
  .clk       (clk),
  .rst       (rst),
  .rd_req    (rd_req),
  .wr_req    (wr_req),
  .wr_wide   (wr_wide),
  .done      (done),
  .far_flag  (far_flag),
  .intercept (intercept),
  .ip_out    (ip_out),
  .sp_out    (sp_out)
);

// File: tb/call_exec_unit_bench.sv
module call_exec_unit_bench;
  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [2:0]  modrm_reg = '0;
  logic        wide_op = 1'b0;
  logic [31:0] disp_imm = '0, reg_operand = '0, base_reg = '0, ea_disp = '0;
  logic [31:0] next_ip = '0, sp_in = '0, rd_data = '0;
  logic        mem_form = 1'b0, base_is_sp = 1'b0, priv_change = 1'b0, rd_valid = 1'b0;
  logic        rd_req, wr_req, wr_wide, done, far_flag, intercept;
  logic [31:0] rd_addr, wr_addr, wr_data, ip_out, sp_out;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  call_exec_unit u_call_exec_unit (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .modrm_reg(modrm_reg),
    .wide_op(wide_op), .disp_imm(disp_imm), .reg_operand(reg_operand),
    .mem_form(mem_form), .base_is_sp(base_is_sp), .base_reg(base_reg),
    .ea_disp(ea_disp), .next_ip(next_ip), .sp_in(sp_in), .priv_change(priv_change),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_wide(wr_wide),
    .done(done), .far_flag(far_flag), .intercept(intercept),
    .ip_out(ip_out), .sp_out(sp_out)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [2:0]  rg;
    logic        wide;
    logic [31:0] imm;
    logic [31:0] regop;
    logic        memf;
    logic        bsp;
    logic [31:0] breg;
    logic [31:0] edisp;
    logic [31:0] nip;
    logic [31:0] sp;
    logic        priv;
    logic [31:0] mdata;
    logic        e_far;
    logic        e_int;
    logic        e_rd;
    logic [31:0] e_rdaddr;
    logic [31:0] e_ip;
    logic [31:0] e_sp;
    logic [31:0] e_wdata;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // R1 relative, 32-bit, forward
    '{8'hE8, 3'd0, 1'b1, 32'h0000_0100, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0040_1005, 32'h0008_0000, 1'b0, 32'h0,
      1'b0, 1'b0, 1'b0, 32'h0, 32'h0040_1105, 32'h0007_FFFC, 32'h0040_1005},
    // R1 relative, 32-bit, backward
    '{8'hE8, 3'd0, 1'b1, 32'hFFFF_FFF0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0040_1010, 32'h0000_1000, 1'b0, 32'h0,
      1'b0, 1'b0, 1'b0, 32'h0, 32'h0040_1000, 32'h0000_0FFC, 32'h0040_1010},
    // R1 R5 relative, 16-bit, negative, upper immediate bits ignored
    '{8'hE8, 3'd0, 1'b0, 32'hABCD_FFFE, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_1234, 32'h0000_2000, 1'b0, 32'h0,
      1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_1232, 32'h0000_1FFE, 32'h0000_1234},
    // R5 relative, 16-bit, wraps past 64K
    '{8'hE8, 3'd0, 1'b0, 32'h0000_0010, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0001_FFF8, 32'h0000_0100, 1'b0, 32'h0,
      1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_0008, 32'h0000_00FE, 32'h0000_FFF8},
    // R2 register, 32-bit
    '{8'hFF, 3'd2, 1'b1, 32'h0, 32'h00C0_FFEE, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0050_0002, 32'h0000_3000, 1'b0, 32'h0,
      1'b0, 1'b0, 1'b0, 32'h0, 32'h00C0_FFEE, 32'h0000_2FFC, 32'h0050_0002},
    // R2 R5 register, 16-bit
    '{8'hFF, 3'd2, 1'b0, 32'h0, 32'h1234_ABCD, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_0777, 32'h0000_4000, 1'b0, 32'h0,
      1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_ABCD, 32'h0000_3FFE, 32'h0000_0777},
    // R3 memory, base register
    '{8'hFF, 3'd2, 1'b1, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0001_0000, 32'h8, 32'h0040_0006, 32'h0000_5000, 1'b0, 32'h0060_0000,
      1'b0, 1'b0, 1'b1, 32'h0001_0008, 32'h0060_0000, 32'h0000_4FFC, 32'h0040_0006},
    // R3 memory, stack pointer base uses pre-push value
    '{8'hFF, 3'd2, 1'b1, 32'h0, 32'h0, 1'b1, 1'b1, 32'hDEAD_0000, 32'h4, 32'h0040_0100, 32'h0000_6000, 1'b0, 32'h0070_0000,
      1'b0, 1'b0, 1'b1, 32'h0000_6004, 32'h0070_0000, 32'h0000_5FFC, 32'h0040_0100},
    // R3 R5 memory, 16-bit
    '{8'hFF, 3'd2, 1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0000_0100, 32'h0, 32'h0000_2222, 32'h0000_7000, 1'b0, 32'hFFFF_8888,
      1'b0, 1'b0, 1'b1, 32'h0000_0100, 32'h0000_8888, 32'h0000_6FFE, 32'h0000_2222},
    // R7 direct far, no privilege change
    '{8'h9A, 3'd0, 1'b1, 32'h1111_1111, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0040_0200, 32'h0000_9000, 1'b0, 32'h0,
      1'b1, 1'b0, 1'b0, 32'h0, 32'h0000_8888, 32'h0000_6FFE, 32'h0},
    // R8 indirect far with privilege change
    '{8'hFF, 3'd3, 1'b1, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0000_0300, 32'h0, 32'h0040_0300, 32'h0000_9000, 1'b1, 32'h0,
      1'b1, 1'b1, 1'b0, 32'h0, 32'h0000_8888, 32'h0000_6FFE, 32'h0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        got_done, got_far, got_int, rd_seen;
  logic [31:0] rd_seen_addr, w_addr, w_data;
  logic        w_wide;
  int          n_rd, n_wr;

  task automatic issue(input vec_t v);
    @(negedge clk);
    opcode = v.op; modrm_reg = v.rg; wide_op = v.wide; disp_imm = v.imm;
    reg_operand = v.regop; mem_form = v.memf; base_is_sp = v.bsp; base_reg = v.breg;
    ea_disp = v.edisp; next_ip = v.nip; sp_in = v.sp; priv_change = v.priv; rd_data = v.mdata;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // inputs change right after start so only captured values can matter
    sp_in = 32'hFFFF_0000; next_ip = 32'hFFFF_0000; base_reg = 32'hFFFF_0000;
  endtask

  task automatic observe(input int cycles);
    got_done = 0; got_far = 0; got_int = 0; rd_seen = 0; n_rd = 0; n_wr = 0;
    rd_seen_addr = '0; w_addr = '0; w_data = '0; w_wide = 0;
    for (int c = 0; c < cycles && !got_done; c++) begin
      if (rd_req && !rd_valid) begin
        n_rd++; rd_seen = 1; rd_seen_addr = rd_addr; rd_valid = 1'b1;
      end else begin
        rd_valid = 1'b0;
      end
      if (wr_req) begin
        n_wr++; w_addr = wr_addr; w_data = wr_data; w_wide = wr_wide;
      end
      if (done) begin
        got_done = 1; got_far = far_flag; got_int = intercept;
      end
      @(negedge clk);
    end
    rd_valid = 1'b0;
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    v = VECS[i];
    issue(v);
    observe(20);
    chk(got_done == 1'b1, "R6 done seen", 32'(got_done), 32'd1);
    chk(got_far == v.e_far, "R7 far_flag", 32'(got_far), 32'(v.e_far));
    chk(got_int == v.e_int, "R8 intercept", 32'(got_int), 32'(v.e_int));
    chk(n_rd == (v.e_rd ? 1 : 0), "R3 read count", 32'(n_rd), 32'(v.e_rd));
    if (v.e_rd) chk(rd_seen_addr == v.e_rdaddr, "R3 read address", rd_seen_addr, v.e_rdaddr);
    chk(n_wr == (v.e_far ? 0 : 1), "R6 write count", 32'(n_wr), v.e_far ? 32'd0 : 32'd1);
    if (!v.e_far) begin
      chk(w_addr == v.e_sp, "R4 write address", w_addr, v.e_sp);
      chk(w_data == v.e_wdata, "R4 write data", w_data, v.e_wdata);
      chk(w_wide == v.wide, "R4 write size", 32'(w_wide), 32'(v.wide));
    end
    chk(ip_out == v.e_ip, "R1 R2 R3 R5 R7 ip_out", ip_out, v.e_ip);
    chk(sp_out == v.e_sp, "R4 R7 sp_out", sp_out, v.e_sp);
  endtask

  task automatic run_ignored(input logic [7:0] op, input logic [2:0] rg);
    vec_t v;
    logic [31:0] ip_before, sp_before;
    v = VECS[0];
    v.op = op; v.rg = rg; v.memf = 1'b1;
    ip_before = ip_out; sp_before = sp_out;
    issue(v);
    observe(8);
    chk(!got_done, "R9 no done", 32'(got_done), 32'd0);
    chk(n_rd == 0 && n_wr == 0, "R9 no traffic", 32'(n_rd + n_wr), 32'd0);
    chk(ip_out == ip_before && sp_out == sp_before, "R9 pointers kept", ip_out, ip_before);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(!done && !rd_req && !wr_req, "R10 idle after reset", {29'd0, done, rd_req, wr_req}, 32'd0);
    chk(ip_out == 0 && sp_out == 0, "R10 pointers cleared", ip_out | sp_out, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R9 unrelated opcode and unused reg field
    run_ignored(8'h90, 3'd0);
    run_ignored(8'hFF, 3'd4);

    // R10 reset while a memory-indirect call waits for data
    issue(VECS[6]);
    chk(rd_req == 1'b1, "R3 read pending", 32'(rd_req), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!rd_req && !wr_req && !done, "R10 abort", {29'd0, rd_req, wr_req, done}, 32'd0);
    chk(ip_out == 0 && sp_out == 0, "R10 pointers cleared mid-call", ip_out | sp_out, 32'd0);
    rd_valid = 1'b1;
    observe(6);
    chk(!got_done && n_wr == 0, "R10 no stale write", 32'(n_wr), 32'd0);

    // recovery after reset
    run_vec(0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule